// File: doc/BRIEF.md
# Multicast group hash filter

This block decides whether a received group destination address falls in the set of groups software has asked to accept. The six address bytes arrive one per clock, first byte first. The block runs a CRC-32 over them and takes the top eight bits of the result as an index into a 256-entry bit table. The table is held as eight 32-bit words. When the address is a group address, a one-cycle strobe reports whether the indexed table bit is set.

Software reaches the table through a simple word port. It writes a whole word, and it reads any word back combinationally. Each address can also carry a command. The command either only checks the table, or sets or clears the table bit the address hashes to. The bit update lands at the end of the cycle in which the result is reported. A driver can therefore join or leave a group by presenting the group address, and needs no hash arithmetic of its own.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table words read as zero on `reg_rdata`.
- R2: A word written with `reg_we` high is stored at `reg_addr` on that clock edge. `reg_rdata` shows the word selected by `reg_addr` combinationally.
- R3: The hash is computed over the six address bytes, each processed least significant bit first. It starts from 0xFFFFFFFF and uses polynomial 0x04C11DB7 in a left-shifting register: per bit, the register is shifted left by one and XORed with the polynomial when its old bit 31 XOR the data bit is 1. The result is not complemented. The index is bits 31..24 of the result. It appears on `hash_index` in the cycle after the sixth byte is accepted and holds until the next address completes.
- R4: Index i maps to word i[7:5], bit (31 − i[4:0]). Entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7.
- R5: When the first byte has bit 0 set (group address), `match_valid` is high for exactly the one cycle after the sixth byte. In that cycle `match` equals the indexed table bit as it stood before any update from this address.
- R6: When bit 0 of the first byte is 0, `match_valid` stays low for that address. `hash_index` is still updated.
- R7: `addr_op` is sampled with the first byte. A value of 01 sets the indexed bit and leaves every other table bit unchanged. The update is visible on `reg_rdata` from the cycle after the result cycle.
- R8: `addr_op` = 10 clears the indexed bit and leaves every other table bit unchanged. Values 00 and 11 leave the table unchanged.
- R9: A register write in the result cycle to the word a set or clear command targets wins: the word takes the written value. A write to a different word in the same cycle is applied along with the command.
- R10: A byte with `addr_sof` high always starts a new address and discards any partial one. Valid bytes without `addr_sof` while no address is in progress are ignored: no strobe, and no change to `hash_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Address byte present |
| addr_sof | input | 1 | Marks the first address byte |
| addr_byte | input | 8 | Address byte |
| addr_op | input | 2 | Command captured with the first byte: 00/11 check, 01 set, 10 clear |
| reg_we | input | 1 | Table word write enable |
| reg_addr | input | 3 | Table word select for write and read |
| reg_wdata | input | 32 | Table word write data |
| reg_rdata | output | 32 | Selected table word |
| match_valid | output | 1 | One-cycle strobe: group address lookup result |
| match | output | 1 | Indexed table bit, valid with `match_valid` |
| hash_index | output | 8 | Index of the last completed address |

## Verification
A sweep of 256 group addresses, each differing in its last two bytes, is checked against an arithmetic CRC model. The sweep is run against an empty table, against a dense written pattern and during set and clear commands. Together these separate wrong CRC bit ordering from a wrong word/bit mapping or an inverted bit numbering. Addresses with the group bit clear show that the strobe is gated while the index still updates. Stray bytes and an abandoned partial address show that framing restarts correctly. A write placed in the result cycle, on the commanded word and on a different word, shows which update wins.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int REGS       = 8,
  parameter int WIDTH      = 32,
  parameter int ADDR_BYTES = 6,
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_valid,
  input  logic                     addr_sof,
  input  logic [7:0]               addr_byte,
  input  logic [1:0]               addr_op,
  input  logic                     reg_we,
  input  logic [$clog2(REGS)-1:0]  reg_addr,
  input  logic [WIDTH-1:0]         reg_wdata,
  output logic [WIDTH-1:0]         reg_rdata,
  output logic                     match_valid,
  output logic                     match,
  output logic [$clog2(REGS)+$clog2(WIDTH)-1:0] hash_index
);
  localparam int SEL_W = $clog2(REGS);
  localparam int BIT_W = $clog2(WIDTH);
  localparam int IDX_W = SEL_W + BIT_W;
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[b]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [WIDTH-1:0] tbl [REGS];
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       op_q;
  logic             ig_q, done_q;
  logic [IDX_W-1:0] idx_q;

  wire [31:0]      crc_nxt = crc_step(addr_sof ? 32'hFFFFFFFF : crc_q, addr_byte);
  wire [SEL_W-1:0] sel     = idx_q[IDX_W-1:BIT_W];
  wire [BIT_W-1:0] bpos    = BIT_W'(WIDTH - 1) - idx_q[BIT_W-1:0];
  wire             cmd_set = done_q && (op_q == 2'b01);
  wire             cmd_clr = done_q && (op_q == 2'b10);

  assign reg_rdata   = tbl[reg_addr];
  assign match_valid = done_q && ig_q;
  assign match       = tbl[sel][bpos];
  assign hash_index  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= 32'hFFFFFFFF;
      cnt    <= '0;
      op_q   <= 2'b00;
      ig_q   <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (addr_valid && addr_sof) begin
        crc_q <= crc_nxt;
        cnt   <= CNT_W'(1);
        op_q  <= addr_op;
        ig_q  <= addr_byte[0];
      end else if (addr_valid && cnt != '0) begin
        crc_q <= crc_nxt;
        if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
          cnt    <= '0;
          done_q <= 1'b1;
          idx_q  <= crc_nxt[31 -: IDX_W];
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  for (genvar r = 0; r < REGS; r++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl[r] <= '0;
      else if (reg_we && reg_addr == SEL_W'(r))
        tbl[r] <= reg_wdata;
      else if (cmd_set && sel == SEL_W'(r))
        tbl[r][bpos] <= 1'b1;
      else if (cmd_clr && sel == SEL_W'(r))
        tbl[r][bpos] <= 1'b0;
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid);

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == $past(reg_wdata) || reg_addr != $past(reg_addr));

  // R7
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set && !(reg_we && reg_addr == sel)) |=> tbl[$past(sel)][$past(bpos)]);

  // R7
  set_only_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set && !reg_we) |=> $countones(tbl[$past(sel)]) <= $countones($past(tbl[sel])) + 1);

  // R8
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !(reg_we && reg_addr == sel)) |=> !tbl[$past(sel)][$past(bpos)]);

  // R10
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_sof && cnt == '0) |=> $stable(crc_q) && !done_q);
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0, addr_sof = 1'b0;
  logic [7:0]  addr_byte = 8'h00;
  logic [1:0]  addr_op = 2'b00;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        match_valid, match;
  logic [7:0]  hash_index;

  mcast_hash_filter u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_sof(addr_sof),
    .addr_byte(addr_byte), .addr_op(addr_op), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_valid(match_valid),
    .match(match), .hash_index(hash_index));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [31:0] mtbl [8];
  logic [7:0]  ab [6];
  logic        s_mv, s_m;
  logic [7:0]  s_idx;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_idx();
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[31] ^ ((ab[i] >> b) & 8'h01) != 0;
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:24];
  endfunction

  function automatic logic model_bit(input logic [7:0] i);
    return mtbl[i / 32][31 - (i % 32)];
  endfunction

  task automatic set_addr(input logic [7:0] b0, input logic [15:0] k);
    ab[0] = b0; ab[1] = 8'h00; ab[2] = 8'h5E; ab[3] = 8'h12;
    ab[4] = k[15:8]; ab[5] = k[7:0];
  endtask

  task automatic send(input logic [1:0] op, input logic wr, input logic [2:0] wa,
                      input logic [31:0] wd);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      addr_valid = 1'b1; addr_sof = (i == 0); addr_byte = ab[i]; addr_op = op;
    end
    @(negedge clk);
    s_mv = match_valid; s_m = match; s_idx = hash_index;
    addr_valid = 1'b0; addr_sof = 1'b0;
    reg_we = wr; reg_addr = wa; reg_wdata = wd;
    @(negedge clk);
    chk("R5 strobe drops", {31'b0, match_valid}, 32'h0);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  ix;
    for (int r = 0; r < 8; r++) mtbl[r] = 32'h0;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); chk("R1 reset word", d, 32'h0); end

    // R3 R5 empty table sweep
    for (int k = 0; k < 256; k++) begin
      set_addr(8'h01, 16'(k * 7 + 3));
      send(2'b00, 1'b0, 3'd0, 32'h0);
      chk("R3 index", {24'h0, s_idx}, {24'h0, model_idx()});
      chk("R5 strobe", {31'b0, s_mv}, 32'h1);
      chk("R5 empty match", {31'b0, s_m}, 32'h0);
    end

    // R2 writes and readback
    for (int r = 0; r < 8; r++) begin
      mtbl[r] = 32'hA5C3_0F96 ^ (32'h1357_9BDF * 32'(r + 1));
      wr(3'(r), mtbl[r]);
    end
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); chk("R2 readback", d, mtbl[r]); end

    // R4 R5 patterned sweep, ops 00 and 11 leave table alone (R8)
    for (int k = 0; k < 256; k++) begin
      set_addr(8'h01, 16'(k * 13 + 1));
      send((k % 2 == 0) ? 2'b00 : 2'b11, 1'b0, 3'd0, 32'h0);
      chk("R4 mapped match", {31'b0, s_m}, {31'b0, model_bit(model_idx())});
    end
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); chk("R8 check ops no change", d, mtbl[r]); end

    // R7 set sweep from empty
    for (int r = 0; r < 8; r++) begin mtbl[r] = 32'h0; wr(3'(r), 32'h0); end
    for (int k = 0; k < 256; k++) begin
      set_addr(8'h01, 16'(k * 5 + 9));
      ix = model_idx();
      send(2'b01, 1'b0, 3'd0, 32'h0);
      chk("R7 prior bit", {31'b0, s_m}, {31'b0, model_bit(ix)});
      mtbl[ix / 32][31 - (ix % 32)] = 1'b1;
      rd(3'(ix / 32), d); chk("R7 set word", d, mtbl[ix / 32]);
    end
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); chk("R7 all words", d, mtbl[r]); end

    // R8 clear sweep, group bit both ways; R6 gating
    for (int k = 0; k < 256; k++) begin
      set_addr((k % 2 == 0) ? 8'h01 : 8'h00, 16'(k * 5 + 9));
      ix = model_idx();
      send(2'b10, 1'b0, 3'd0, 32'h0);
      chk("R6 strobe gate", {31'b0, s_mv}, (k % 2 == 0) ? 32'h1 : 32'h0);
      chk("R6 index updates", {24'h0, s_idx}, {24'h0, ix});
      mtbl[ix / 32][31 - (ix % 32)] = 1'b0;
      rd(3'(ix / 32), d); chk("R8 clear word", d, mtbl[ix / 32]);
    end
    for (int r = 0; r < 8; r++) begin rd(3'(r), d); chk("R8 all words", d, mtbl[r]); end

    // R9 priority, same word then different word
    set_addr(8'h01, 16'h0042); ix = model_idx();
    send(2'b01, 1'b1, 3'(ix / 32), 32'h0000_1000);
    mtbl[ix / 32] = 32'h0000_1000;
    rd(3'(ix / 32), d); chk("R9 write wins", d, 32'h0000_1000);
    send(2'b01, 1'b1, 3'((ix / 32 + 1) % 8), 32'hDEAD_BEEF);
    mtbl[(ix / 32 + 1) % 8] = 32'hDEAD_BEEF;
    mtbl[ix / 32][31 - (ix % 32)] = 1'b1;
    rd(3'(ix / 32), d); chk("R9 command applied", d, mtbl[ix / 32]);
    rd(3'((ix / 32 + 1) % 8), d); chk("R9 other write applied", d, 32'hDEAD_BEEF);

    // R10 stray bytes and restart
    s_idx = hash_index;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr_valid = 1'b1; addr_sof = 1'b0; addr_byte = 8'(i * 37);
      chk("R10 stray no strobe", {31'b0, match_valid}, 32'h0);
    end
    @(negedge clk); addr_valid = 1'b0;
    chk("R10 stray no strobe", {31'b0, match_valid}, 32'h0);
    chk("R10 index held", {24'h0, hash_index}, {24'h0, s_idx});
    set_addr(8'h01, 16'h7777);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); addr_valid = 1'b1; addr_sof = (i == 0); addr_byte = ab[i];
    end
    set_addr(8'h03, 16'h1234);
    send(2'b00, 1'b0, 3'd0, 32'h0);
    chk("R10 restart index", {24'h0, s_idx}, {24'h0, model_idx()});
    chk("R10 restart strobe", {31'b0, s_mv}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule